// File: doc/BRIEF.md
# Auto-Increment Register Burst Sequencer

This block sits between a byte-oriented monitor-channel receiver, the matching transmitter and a register file with one synchronous read/write port. The first received byte of a transfer is a command, the second is the start register address, and what follows depends on the command. A write transfer writes each further received byte to the register file, one address higher each time. A read transfer turns the response direction toward the transmitter and streams register contents one byte per transmitter request, again one address higher each time.

Before each access, the current address is checked against a legality mask. An illegal address, a malformed command or a byte arriving while data flows outward raises a one-cycle abort request. The block then halts and ignores everything until the end of the message. Accesses made earlier in the same transfer stay committed, and no register is touched by an aborted step. End of message always returns the block to idle. If it comes before the command is complete, nothing else happens.

Top module: `mon_burst_seq`

## Requirements
- R1: During and right after reset, `rf_en`, `rf_we`, `tx_valid`, `tx_dir` and `abort` are low and the block waits for a command byte.
- R2: Command byte encoding: bit 7 = 1 selects read and bit 7 = 0 selects write. Bits 6..0 must be zero. If any of them is set, `abort` pulses in the cycle after the byte, no register access is made, and the block halts.
- R3: In a write transfer, the byte after the command is the start address A. The k-th following data byte (k from 0) produces a one-cycle `rf_en`=1, `rf_we`=1 strobe with `rf_addr`=A+k and `rf_wdata` = that byte, in the cycle after the byte is received.
- R4: In a read transfer, the cycle after the address byte A shows a read strobe (`rf_en`=1, `rf_we`=0, `rf_addr`=A) and `tx_dir`=1. Two cycles after each read strobe, `tx_valid` pulses with `tx_byte` = the register content. Each `tx_req` pulse then issues the next read at the incremented address.
- R5: An address a is legal only when a < 2^ADDR_W and `legal_mask[a]`=1. An access to an illegal address is not made, and `abort` pulses instead. Writes done earlier in the same transfer remain in the register file.
- R6: After an abort, received bytes and `tx_req` cause no access, no `tx_valid` and no further abort until end of message.
- R7: End of message before the command and address are both received returns to idle with no abort and no access, so the next byte is decoded as a new command.
- R8: When `rx_eom` coincides with `rx_valid` or `tx_req`, end of message wins. The byte or request is dropped, no access or abort follows, and `tx_dir` falls.
- R9: A received byte during the read phase (while `tx_dir`=1) is an invalid sequence. `abort` pulses and the block halts.
- R10: `abort` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_eom | input | 1 | End-of-message strobe from the receiver |
| tx_req | input | 1 | Transmitter asks for the next read byte |
| legal_mask | input | 2^ADDR_W | One bit per register address, 1 = accessible |
| rf_en | output | 1 | Register file access strobe |
| rf_we | output | 1 | Access is a write |
| rf_addr | output | ADDR_W | Register address |
| rf_wdata | output | 8 | Write data |
| rf_rdata | input | 8 | Read data, valid one cycle after a read strobe |
| tx_valid | output | 1 | `tx_byte` holds a new read byte |
| tx_byte | output | 8 | Read byte for the transmitter |
| tx_dir | output | 1 | 1 while the response direction points at the transmitter |
| abort | output | 1 | One-cycle abort request |

## Verification
End of message can land in the same cycle as a write data byte or as a transmitter request for the next read byte. In each case it must cancel the access rather than let it go through. The bench provokes both cases by raising `rx_eom` in the same cycle as `rx_valid` in a write burst, and in the same cycle as `tx_req` in a read burst. It then requires a silent cycle with no strobe, no abort and `tx_dir` low. A fresh, complete write transfer afterwards must land at its own start address, which shows the block really returned to idle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_RDISS,
    ST_RDCAP,
    ST_RDREQ,
    ST_HALT
  } seq_st_e;

  typedef struct packed {
    logic ok;
    logic rd;
  } cmd_t;

  // top bit picks direction, every other bit must be clear
  function automatic cmd_t cmd_decode(logic [BYTE_W-1:0] b);
    cmd_t c;
    c.rd = b[BYTE_W-1];
    c.ok = (b[BYTE_W-2:0] == '0);
    return c;
  endfunction
endpackage

// File: rtl/mbs_addr_ctr.sv
module mbs_addr_ctr
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              step,
  input  logic [DEPTH-1:0]  mask,
  output logic [BYTE_W-1:0] cur,
  output logic              cur_legal,
  output logic              load_legal
);
  function automatic logic addr_legal(logic [BYTE_W-1:0] a, logic [DEPTH-1:0] m);
    return (a < BYTE_W'(DEPTH)) && m[a[ADDR_W-1:0]];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= load_val;
    else if (step) cur <= cur + 1'b1;
  end

  assign cur_legal  = addr_legal(cur, mask);
  assign load_legal = addr_legal(load_val, mask);
endmodule

// File: rtl/mbs_rf_drive.sv
module mbs_rf_drive
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_wr,
  input  logic              issue_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              rf_en,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [BYTE_W-1:0] rf_wdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_en    <= 1'b0;
      rf_we    <= 1'b0;
      rf_addr  <= '0;
      rf_wdata <= '0;
    end else begin
      rf_en <= issue_wr | issue_rd;
      rf_we <= issue_wr;
      if (issue_wr | issue_rd) rf_addr <= acc_addr;
      if (issue_wr) rf_wdata <= wdata;
    end
  end
endmodule

// File: rtl/mbs_rd_stream.sv
module mbs_rd_stream
  import mbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [BYTE_W-1:0] rdata,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= cap;
      if (cap) tx_byte <= rdata;
    end
  end
endmodule

// File: rtl/mon_burst_seq.sv
module mon_burst_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_eom,
  input  logic              tx_req,
  input  logic [DEPTH-1:0]  legal_mask,
  output logic              rf_en,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [7:0]        rf_wdata,
  input  logic [7:0]        rf_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              tx_dir,
  output logic              abort
);
  seq_st_e st, st_n;
  logic    is_rd_q, is_rd_n;
  logic    abort_d;
  logic    ld, step, cap, issue_wr, issue_rd, use_load;
  logic [BYTE_W-1:0] cur;
  logic    cur_legal, load_legal;
  logic [ADDR_W-1:0] acc_addr;
  cmd_t    cmd;

  // named internal events for the checker
  logic st_halt;
  logic st_read_phase;

  assign cmd           = cmd_decode(rx_byte);
  assign st_halt       = (st == ST_HALT);
  assign st_read_phase = (st == ST_RDISS) || (st == ST_RDCAP) || (st == ST_RDREQ);
  assign acc_addr      = use_load ? rx_byte[ADDR_W-1:0] : cur[ADDR_W-1:0];

  always_comb begin
    st_n     = st;
    is_rd_n  = is_rd_q;
    abort_d  = 1'b0;
    ld       = 1'b0;
    step     = 1'b0;
    cap      = 1'b0;
    issue_wr = 1'b0;
    issue_rd = 1'b0;
    use_load = 1'b0;
    if (rx_eom) begin
      st_n = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (rx_valid) begin
          if (cmd.ok) begin
            st_n    = ST_ADDR;
            is_rd_n = cmd.rd;
          end else begin
            abort_d = 1'b1;
            st_n    = ST_HALT;
          end
        end
        ST_ADDR: if (rx_valid) begin
          ld = 1'b1;
          if (!is_rd_q) begin
            st_n = ST_WDATA;
          end else if (load_legal) begin
            issue_rd = 1'b1;
            use_load = 1'b1;
            st_n     = ST_RDISS;
          end else begin
            abort_d = 1'b1;
            st_n    = ST_HALT;
          end
        end
        ST_WDATA: if (rx_valid) begin
          if (cur_legal) begin
            issue_wr = 1'b1;
            step     = 1'b1;
          end else begin
            abort_d = 1'b1;
            st_n    = ST_HALT;
          end
        end
        ST_RDISS: begin
          if (rx_valid) begin
            abort_d = 1'b1;
            st_n    = ST_HALT;
          end else begin
            step = 1'b1;
            st_n = ST_RDCAP;
          end
        end
        ST_RDCAP: begin
          if (rx_valid) begin
            abort_d = 1'b1;
            st_n    = ST_HALT;
          end else begin
            cap  = 1'b1;
            st_n = ST_RDREQ;
          end
        end
        ST_RDREQ: begin
          if (rx_valid) begin
            abort_d = 1'b1;
            st_n    = ST_HALT;
          end else if (tx_req) begin
            if (cur_legal) begin
              issue_rd = 1'b1;
              st_n     = ST_RDISS;
            end else begin
              abort_d = 1'b1;
              st_n    = ST_HALT;
            end
          end
        end
        ST_HALT: st_n = ST_HALT;
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      is_rd_q <= 1'b0;
      abort   <= 1'b0;
    end else begin
      st      <= st_n;
      is_rd_q <= is_rd_n;
      abort   <= abort_d;
    end
  end

  assign tx_dir = st_read_phase;

  mbs_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (ld),
    .load_val   (rx_byte),
    .step       (step),
    .mask       (legal_mask),
    .cur        (cur),
    .cur_legal  (cur_legal),
    .load_legal (load_legal)
  );

  mbs_rf_drive #(.ADDR_W(ADDR_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_wr (issue_wr),
    .issue_rd (issue_rd),
    .acc_addr (acc_addr),
    .wdata    (rx_byte),
    .rf_en    (rf_en),
    .rf_we    (rf_we),
    .rf_addr  (rf_addr),
    .rf_wdata (rf_wdata)
  );

  mbs_rd_stream u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (cap),
    .rdata    (rf_rdata),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte)
  );
endmodule

// File: rtl/mbs_chk.sv
module mbs_chk #(
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_eom,
  input logic              abort,
  input logic              rf_en,
  input logic              rf_we,
  input logic [ADDR_W-1:0] rf_addr,
  input logic              tx_valid,
  input logic              tx_dir,
  input logic [DEPTH-1:0]  legal_mask,
  input logic              in_halt
);
  logic [DEPTH-1:0] mask_q;
  always_ff @(posedge clk) mask_q <= legal_mask;

  // R10
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  // R5
  abort_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !rf_en);

  // R5
  legal_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |-> mask_q[rf_addr]);

  // R4
  tx_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(rf_en && !rf_we, 2));

  // R4
  tx_dir_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_dir);

  // R3
  write_not_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_en && rf_we) |-> !tx_dir);

  // R6
  halt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_halt && !rx_eom) |=> (!rf_en && !tx_valid && !abort));

  // R8
  eom_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eom |=> (!rf_en && !tx_valid && !abort && !tx_dir));
endmodule

bind mon_burst_seq mbs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_eom     (rx_eom),
  .abort      (abort),
  .rf_en      (rf_en),
  .rf_we      (rf_we),
  .rf_addr    (rf_addr),
  .tx_valid   (tx_valid),
  .tx_dir     (tx_dir),
  .legal_mask (legal_mask),
  .in_halt    (st_halt)
);

// File: tb/mon_burst_seq_bench.sv
module mon_burst_seq_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n, rx_valid, rx_eom, tx_req;
  logic [7:0]       rx_byte;
  logic [DEPTH-1:0] mask;
  logic             rf_en, rf_we, tx_valid, tx_dir, abort;
  logic [AW-1:0]    rf_addr;
  logic [7:0]       rf_wdata, rf_rdata, tx_byte;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  mon_burst_seq #(.ADDR_W(AW)) u_mon_burst_seq (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_eom(rx_eom), .tx_req(tx_req), .legal_mask(mask),
    .rf_en(rf_en), .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_dir(tx_dir), .abort(abort)
  );

  function automatic logic [7:0] seed(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  // register file model: synchronous port, read data one cycle after strobe
  logic [7:0] mem [DEPTH];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= seed(i);
      rf_rdata <= 8'h00;
    end else if (rf_en) begin
      if (rf_we) mem[rf_addr] <= rf_wdata;
      else rf_rdata <= mem[rf_addr];
    end
  end

  logic [7:0] expm [DEPTH];

  task automatic chk(input logic ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic eom();
    rx_eom = 1'b1;
    @(negedge clk);
    rx_eom = 1'b0;
  endtask

  task automatic see_write(input int a, input int d, input string rq);
    int act;
    act = (rf_en && rf_we) ? ((int'(rf_addr) << 8) | int'(rf_wdata)) : -1;
    chk(act == ((a << 8) | d), rq, "write strobe", act, (a << 8) | d);
  endtask

  task automatic see_read_issue(input int a, input string rq);
    int act;
    act = (rf_en && !rf_we) ? int'(rf_addr) : -1;
    chk(act == a, rq, "read strobe", act, a);
  endtask

  task automatic see_quiet(input string rq);
    chk(!rf_en && !abort && !tx_valid, rq, "quiet {en,abort,txv}",
        {rf_en, abort, tx_valid}, 0);
  endtask

  task automatic see_abort(input string rq);
    chk(abort && !rf_en, rq, "abort {abort,en}", {abort, rf_en}, 2);
    @(negedge clk);
    chk(!abort, "R10", "abort drops", abort, 0);
  endtask

  // call right after the read strobe is visible
  task automatic see_tx(input int a, input string rq);
    @(negedge clk);
    chk(!tx_valid, rq, "tx early", tx_valid, 0);
    @(negedge clk);
    chk(tx_valid && tx_byte == expm[a] && tx_dir, rq, "tx byte",
        tx_valid ? int'(tx_byte) : -1, expm[a]);
  endtask

  task automatic pulse_req();
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
  endtask

  task automatic t_reset();
    chk(!rf_en && !rf_we && !tx_valid && !tx_dir && !abort, "R1", "outputs in reset",
        {rf_en, rf_we, tx_valid, tx_dir, abort}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rf_en && !rf_we && !tx_valid && !tx_dir && !abort, "R1", "outputs after reset",
        {rf_en, rf_we, tx_valid, tx_dir, abort}, 0);
  endtask

  task automatic t_write_burst();
    send(8'h00); see_quiet("R2");
    send(8'h10); see_quiet("R3");
    send(8'hA1); see_write(16, 8'hA1, "R3"); expm[16] = 8'hA1;
    send(8'hB2); see_write(17, 8'hB2, "R3"); expm[17] = 8'hB2;
    send(8'hC3); see_write(18, 8'hC3, "R3"); expm[18] = 8'hC3;
    chk(!tx_dir, "R3", "dir during write", tx_dir, 0);
    eom();
  endtask

  task automatic t_read_burst();
    send(8'h80); see_quiet("R2");
    send(8'h05); see_read_issue(5, "R4");
    chk(tx_dir, "R4", "dir on read", tx_dir, 1);
    see_tx(5, "R4");
    pulse_req(); see_read_issue(6, "R4"); see_tx(6, "R4");
    pulse_req(); see_read_issue(7, "R4"); see_tx(7, "R4");
    eom();
    chk(!tx_dir, "R4", "dir after eom", tx_dir, 0);
  endtask

  task automatic t_bad_cmd();
    send(8'h81); see_abort("R2");
    send(8'h00); see_quiet("R6");
    send(8'h10); see_quiet("R6");
    send(8'h55); see_quiet("R6");
    eom();
    send(8'h00); send(8'h21);
    send(8'h3C); see_write(33, 8'h3C, "R6"); expm[33] = 8'h3C;
    eom();
  endtask

  task automatic t_write_into_hole();
    send(8'h00); send(8'd18);
    send(8'h11); see_write(18, 8'h11, "R5"); expm[18] = 8'h11;
    send(8'h22); see_write(19, 8'h22, "R5"); expm[19] = 8'h22;
    send(8'h33); see_abort("R5");
    send(8'h44); see_quiet("R6");
    eom();
    // earlier writes of the failed transfer must still be there
    send(8'h80); send(8'd18); see_read_issue(18, "R5"); see_tx(18, "R5");
    pulse_req(); see_read_issue(19, "R5"); see_tx(19, "R5");
    eom();
  endtask

  task automatic t_read_into_hole();
    send(8'h80); send(8'd61); see_read_issue(61, "R5"); see_tx(61, "R5");
    pulse_req(); see_abort("R5");
    chk(!tx_dir, "R6", "dir after abort", tx_dir, 0);
    pulse_req(); see_quiet("R6");
    eom();
    send(8'h80); send(8'h50); see_abort("R5");
    chk(!tx_dir, "R5", "dir on range fail", tx_dir, 0);
    eom();
  endtask

  task automatic t_early_eom();
    send(8'h00); eom(); see_quiet("R7");
    send(8'h00); send(8'h03);
    send(8'h5A); see_write(3, 8'h5A, "R7"); expm[3] = 8'h5A;
    eom();
    send(8'h80); eom(); see_quiet("R7");
    chk(!tx_dir, "R7", "dir after early eom", tx_dir, 0);
  endtask

  task automatic t_eom_collide();
    send(8'h00); send(8'h08);
    send(8'h66); see_write(8, 8'h66, "R8"); expm[8] = 8'h66;
    rx_valid = 1'b1; rx_byte = 8'h77; rx_eom = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_eom = 1'b0;
    see_quiet("R8");
    send(8'h00); send(8'h0A);
    send(8'h99); see_write(10, 8'h99, "R8"); expm[10] = 8'h99;
    eom();
    send(8'h80); send(8'h0C); see_read_issue(12, "R8"); see_tx(12, "R8");
    tx_req = 1'b1; rx_eom = 1'b1;
    @(negedge clk);
    tx_req = 1'b0; rx_eom = 1'b0;
    see_quiet("R8");
    chk(!tx_dir, "R8", "dir after eom with req", tx_dir, 0);
  endtask

  task automatic t_byte_in_read();
    send(8'h80); send(8'h02); see_read_issue(2, "R9"); see_tx(2, "R9");
    send(8'h00); see_abort("R9");
    chk(!tx_dir, "R9", "dir after abort", tx_dir, 0);
    eom();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1..: actual 0 expected 1 (run completed)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00; rx_eom = 1'b0; tx_req = 1'b0;
    mask = '1; mask[20] = 1'b0; mask[62] = 1'b0; mask[63] = 1'b0;
    for (int i = 0; i < DEPTH; i++) expm[i] = seed(i);
    repeat (3) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_burst();
    t_bad_cmd();
    t_write_into_hole();
    t_read_into_hole();
    t_early_eom();
    t_eom_collide();
    t_byte_in_read();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule